// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a filter or correlator. Each cycle that a valid operand pair arrives, it forms the exact signed product of two DATA_W-bit two's-complement fractions and either adds it to a running sum or starts a new sum with it. The sum register carries GUARD_W extra bits above the full product, so long runs of taps can build up before any bit of range is lost.

When a store strobe is given, the running sum is converted to a single DATA_W-bit fraction. The DATA_W-1 least significant bits of the sum are dropped using one of three rounding modes. Saturation is applied after rounding, so a value that rounds up past the largest code still clamps correctly. A sticky flag records any store whose word was altered by clamping. The flag stays set until the next sum restart.

With the default sizes (24-bit operands, 48-bit product, 56-bit sum), a fraction value v in the range -1 ≤ v < 1 is held as v·2^23. The sum holds the product scaled by 2^46, so the stored word is the sum shifted right by 23 places.

Top module: `fx_mac`

## Requirements
- R1: While rst_n is low, and at the first edge after it falls, acc_out, res_out and ovf_flag are all zero.
- R2: On an edge where in_valid and clr_load are both high, acc_out becomes the exact sign-extended product op_a·op_b. The earlier sum is discarded. The product of -1 and -1 is represented without loss.
- R3: On an edge where in_valid is high and clr_load is low, acc_out becomes the previous acc_out plus the sign-extended product, taken modulo 2^ACC_W.
- R4: On an edge where in_valid is low, acc_out keeps its value whatever op_a, op_b and clr_load carry.
- R5: On an edge where store is high, res_out takes the conversion of the acc_out value present before that edge. On any other edge, res_out holds its value.
- R6: rnd_mode 2'b00 (truncate) drops the low DATA_W-1 bits of the sum, which is a floor toward minus infinity. rnd_mode 2'b11 behaves the same way.
- R7: rnd_mode 2'b01 (half up) adds one to the kept value when the dropped part is at least one half of a kept LSB. Ties therefore move toward plus infinity.
- R8: rnd_mode 2'b10 (convergent) adds one when the dropped part is above one half. On an exact half, it adds one only if the kept LSB is 1, so the result ends even.
- R9: After rounding, a value above 2^(DATA_W-1)-1 stores as 2^(DATA_W-1)-1, and a value below -2^(DATA_W-1) stores as -2^(DATA_W-1).
- R10: ovf_flag is set by a store whose word was clamped. It stays set until an edge with in_valid and clr_load high, which clears it. A clamped store on that same edge leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| clr_load | input | 1 | With in_valid: restart the sum with the product and clear ovf_flag |
| op_a | input | DATA_W | Signed fractional operand A |
| op_b | input | DATA_W | Signed fractional operand B |
| rnd_mode | input | 2 | Rounding select: 00 truncate, 01 half up, 10 convergent, 11 truncate |
| store | input | 1 | Convert the current sum into res_out |
| acc_out | output | 2*DATA_W+GUARD_W | Full running sum |
| res_out | output | DATA_W | Rounded and saturated word |
| ovf_flag | output | 1 | Sticky clamp indicator |

## Verification
Some properties are checked on every cycle by the assertions. These cover the load, add and hold behaviour of the sum register. They also cover res_out staying put between stores, a clamped word being exactly one of the two extreme codes, and the flag's sticky-set and clear rules.

Other behaviour can only be shown by the bench's directed and mixed scenarios, scored against an independent model. This includes the exact rounding decisions at, below and above the half point for positive and negative sums, a tie with an odd kept LSB, and a half-up round from the largest code that must clamp. It also includes a product of minus one by minus one, and a store and a restart on the same edge.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
   typedef enum logic [1:0] {
      RND_TRUNC   = 2'b00,
      RND_HALF_UP = 2'b01,
      RND_CONV    = 2'b10,
      RND_SPARE   = 2'b11
   } rnd_mode_e;
endpackage

// File: rtl/fxmac_mult.sv
module fxmac_mult #(
   parameter int DATA_W = 24,
   localparam int PROD_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] mul_a,
   input  logic [DATA_W-1:0] mul_b,
   output logic [PROD_W-1:0] mul_p
);
   // full-width signed product, no bits discarded
   assign mul_p = PROD_W'($signed(mul_a) * $signed(mul_b));
endmodule

// File: rtl/fxmac_accum.sv
module fxmac_accum #(
   parameter int PROD_W = 48,
   parameter int ACC_W  = 56,
   localparam int EXT_W = ACC_W - PROD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              restart,
   input  logic [PROD_W-1:0] prod,
   output logic [ACC_W-1:0]  sum_q
);
   logic [ACC_W-1:0] prod_ext;

   if (EXT_W < 1) begin : g_bad_guard
      $error("fxmac_accum: sum must be wider than the product");
   end

   assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

   always_ff @(posedge clk) begin
      if (!rst_n)
         sum_q <= '0;
      else if (take)
         sum_q <= restart ? prod_ext : sum_q + prod_ext;
   end

   a_r2_restart_loads_product: assert property (@(posedge clk) disable iff (!rst_n)
      take && restart |=> sum_q == $past(prod_ext));
   a_r3_adds_product: assert property (@(posedge clk) disable iff (!rst_n)
      take && !restart |=> sum_q == ACC_W'($past(sum_q) + $past(prod_ext)));
   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(sum_q));
endmodule

// File: rtl/fxmac_round_sat.sv
module fxmac_round_sat
   import fxmac_pkg::*;
#(
   parameter int ACC_W  = 56,
   parameter int DATA_W = 24,
   localparam int DROP  = DATA_W - 1,
   localparam int Q_W   = ACC_W - DROP + 1
) (
   input  logic [ACC_W-1:0]  sum_in,
   input  rnd_mode_e         mode,
   output logic [DATA_W-1:0] word,
   output logic              clamped
);
   logic          half_bit;
   logic          below_nz;
   logic          bump;
   logic [Q_W-1:0] kept;
   logic [Q_W-1:0] rounded;
   logic          fits;

   // bits below the half position exist only when more than one bit is dropped
   if (DROP >= 2) begin : g_below
      assign below_nz = |sum_in[DROP-2:0];
   end else begin : g_no_below
      assign below_nz = 1'b0;
   end

   assign half_bit = sum_in[DROP-1];
   assign kept     = {sum_in[ACC_W-1], sum_in[ACC_W-1:DROP]};

   always_comb begin
      unique case (mode)
         RND_HALF_UP: bump = half_bit;
         RND_CONV:    bump = half_bit & (below_nz | sum_in[DROP]);
         default:     bump = 1'b0;
      endcase
   end

   assign rounded = kept + {{(Q_W-1){1'b0}}, bump};
   assign fits    = (&rounded[Q_W-1:DATA_W-1]) | ~(|rounded[Q_W-1:DATA_W-1]);
   assign clamped = ~fits;
   assign word    = fits ? rounded[DATA_W-1:0]
                  : (rounded[Q_W-1] ? {1'b1, {(DATA_W-1){1'b0}}}
                                    : {1'b0, {(DATA_W-1){1'b1}}});
endmodule

// File: rtl/fx_mac.sv
module fx_mac
   import fxmac_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int GUARD_W = 8,
   localparam int PROD_W = 2 * DATA_W,
   localparam int ACC_W  = PROD_W + GUARD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              clr_load,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [1:0]        rnd_mode,
   input  logic              store,
   output logic [ACC_W-1:0]  acc_out,
   output logic [DATA_W-1:0] res_out,
   output logic              ovf_flag
);
   if (DATA_W < 2) begin : g_bad_width
      $error("fx_mac: DATA_W must be at least 2");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("fx_mac: GUARD_W must be at least 1");
   end

   logic [PROD_W-1:0] prod_w;
   logic [DATA_W-1:0] word_w;
   logic              clamp_w;
   logic              restart_w;

   assign restart_w = in_valid & clr_load;

   fxmac_mult #(.DATA_W(DATA_W)) u_mult (
      .mul_a (op_a),
      .mul_b (op_b),
      .mul_p (prod_w)
   );

   fxmac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (in_valid),
      .restart (clr_load),
      .prod    (prod_w),
      .sum_q   (acc_out)
   );

   fxmac_round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_rsat (
      .sum_in  (acc_out),
      .mode    (rnd_mode_e'(rnd_mode)),
      .word    (word_w),
      .clamped (clamp_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_out  <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (store) res_out <= word_w;
         ovf_flag <= (ovf_flag & ~restart_w) | (store & clamp_w);
      end
   end

   a_r5_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !store |=> $stable(res_out));
   a_r9_clamp_is_extreme: assert property (@(posedge clk) disable iff (!rst_n)
      store && clamp_w |=> (res_out == {1'b0, {(DATA_W-1){1'b1}}}) ||
                           (res_out == {1'b1, {(DATA_W-1){1'b0}}}));
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !restart_w |=> ovf_flag);
   a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart_w && !store |=> !ovf_flag);
endmodule

// File: tb/tb_fx_mac.sv
`timescale 1ns/1ps
module tb_fx_mac;
   localparam int N  = 24;
   localparam int G  = 8;
   localparam int AW = 2 * N + G;
   localparam int D  = N - 1;
   localparam longint MAXV = (64'sd1 <<< (N - 1)) - 1;
   localparam longint MINV = -(64'sd1 <<< (N - 1));

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, clr_load = 1'b0, store = 1'b0;
   logic [N-1:0]  op_a = '0, op_b = '0;
   logic [1:0]    rnd_mode = 2'b00;
   logic [AW-1:0] acc_out;
   logic [N-1:0]  res_out;
   logic          ovf_flag;

   fx_mac #(.DATA_W(N), .GUARD_W(G)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr_load(clr_load),
      .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode), .store(store),
      .acc_out(acc_out), .res_out(res_out), .ovf_flag(ovf_flag)
   );

   typedef struct {
      longint acc;
      longint res;
      bit     ovf;
      string  tag;
   } exp_t;

   exp_t   sbq[$];
   int     errors = 0;
   int     checks = 0;
   bit     done = 0;
   longint m_acc = 0, m_res = 0;
   bit     m_ovf = 0;

   function automatic longint sx(longint v, int w);
      return (v <<< (64 - w)) >>> (64 - w);
   endfunction

   function automatic void convert(input longint acc, input int mode,
                                   output longint r, output bit s);
      longint q    = acc >>> D;
      longint frac = acc & ((64'sd1 <<< D) - 1);
      longint half = 64'sd1 <<< (D - 1);
      if (mode == 1 && frac >= half) q = q + 1;
      else if (mode == 2 && (frac > half || (frac == half && q[0]))) q = q + 1;
      s = 1'b0;
      if (q > MAXV) begin q = MAXV; s = 1'b1; end
      else if (q < MINV) begin q = MINV; s = 1'b1; end
      r = q;
   endfunction

   function automatic void check(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endfunction

   // driver: apply one cycle of stimulus and predict the state after the edge
   task automatic step(bit v, bit c, longint a, longint b, bit st, int mode, string tag);
      longint r;
      bit     s;
      exp_t   e;
      @(posedge clk); #2;
      in_valid = v; clr_load = c; op_a = a[N-1:0]; op_b = b[N-1:0];
      store = st; rnd_mode = mode[1:0];
      s = 1'b0;
      if (st) begin
         convert(m_acc, mode, r, s);
         m_res = r;
      end
      m_ovf = ((v && c) ? 1'b0 : m_ovf) | (st & s);
      if (v) begin
         if (c) m_acc = sx(sx(a, N) * sx(b, N), AW);
         else   m_acc = sx(m_acc + sx(a, N) * sx(b, N), AW);
      end
      e.acc = m_acc; e.res = m_res; e.ovf = m_ovf; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: compare after each edge
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (rst_n && sbq.size() > 0) begin
         e = sbq.pop_front();
         check(e.tag, "acc_out", sx(longint'(acc_out), AW), e.acc);
         check(e.tag, "res_out", sx(longint'(res_out), N), e.res);
         check(e.tag, "ovf_flag", longint'(ovf_flag), longint'(e.ovf));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      @(posedge clk); @(posedge clk); #1;
      check("R1", "acc_out", longint'(acc_out), 0);
      check("R1", "res_out", longint'(res_out), 0);
      check("R1", "ovf_flag", longint'(ovf_flag), 0);
      #1 rst_n = 1'b1;

      step(1, 1, 64'sd1 <<< 22, 64'sd1 <<< 22, 0, 0, "R2 load half*half");
      step(1, 0, -(64'sd1 <<< 21), 64'sd1 <<< 22, 0, 0, "R3 add negative");
      step(0, 1, 123, 456, 0, 0, "R4 idle ignores operands");
      step(0, 0, 0, 0, 1, 0, "R5 store truncate");
      step(0, 0, 0, 0, 0, 1, "R5 no store holds");

      // exact half of a kept LSB, kept value 0
      step(1, 1, 64'sd1 <<< 11, 64'sd1 <<< 11, 0, 0, "R2 load tie");
      step(0, 0, 0, 0, 1, 0, "R6 tie truncate");
      step(0, 0, 0, 0, 1, 1, "R7 tie half up");
      step(0, 0, 0, 0, 1, 2, "R8 tie even stays");
      step(0, 0, 0, 0, 1, 3, "R6 spare mode truncates");
      // kept value 1, tie
      step(1, 0, 64'sd1 <<< 12, 64'sd1 <<< 11, 0, 0, "R3 add to odd tie");
      step(0, 0, 0, 0, 1, 2, "R8 tie odd goes even");
      step(0, 0, 0, 0, 1, 1, "R7 odd tie half up");
      step(0, 0, 0, 0, 1, 0, "R6 odd tie truncate");
      // negative tie
      step(1, 1, -(64'sd1 <<< 11), 64'sd1 <<< 11, 0, 0, "R2 load negative tie");
      step(0, 0, 0, 0, 1, 0, "R6 negative floor");
      step(0, 0, 0, 0, 1, 1, "R7 negative tie up");
      step(0, 0, 0, 0, 1, 2, "R8 negative tie even");
      // just above and below half
      step(1, 1, (64'sd1 <<< 11) + 1, 64'sd1 <<< 11, 0, 0, "R2 load above half");
      step(0, 0, 0, 0, 1, 2, "R8 above half rounds up");
      step(1, 1, (64'sd1 <<< 11) - 1, 64'sd1 <<< 11, 0, 0, "R2 load below half");
      step(0, 0, 0, 0, 1, 1, "R7 below half rounds down");

      // minus one squared, then sticky flag
      step(1, 1, MINV, MINV, 0, 0, "R2 minus one squared");
      step(0, 0, 0, 0, 1, 0, "R9 clamp positive");
      step(1, 0, MINV, MAXV, 0, 0, "R3 bring back in range");
      step(0, 0, 0, 0, 1, 0, "R10 flag stays set");
      step(1, 1, 64'sd1 <<< 22, 64'sd1 <<< 22, 0, 0, "R10 restart clears flag");

      // round up from the largest code
      step(1, 1, MAXV, MAXV, 0, 0, "R2 load max squared");
      step(1, 0, 64'sd1 <<< 12, 64'sd1 <<< 11, 0, 0, "R3 add one lsb");
      step(1, 0, (64'sd1 <<< 22) - 1, 1, 0, 0, "R3 add to exact tie");
      step(0, 0, 0, 0, 1, 0, "R6 max truncates no clamp");
      step(0, 0, 0, 0, 1, 1, "R9 half up past max clamps");
      step(1, 1, 1, 1, 1, 2, "R10 clamped store with restart");

      // negative clamp
      step(1, 1, MINV, MAXV, 0, 0, "R2 load min*max");
      step(1, 0, MINV, MAXV, 0, 0, "R3 grow negative");
      step(0, 0, 0, 0, 1, 1, "R9 clamp negative");

      // mixed traffic scored against the model
      for (int i = 0; i < 300; i++) begin
         step($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
              sx(longint'($urandom), N), sx(longint'($urandom), N),
              $urandom_range(0, 2) == 0, $urandom_range(0, 3), "R3 mixed traffic");
      end

      step(0, 0, 0, 0, 0, 0, "R4 drain");
      @(posedge clk); @(posedge clk); #3;
      finish_run();
   end
endmodule